// File: doc/BRIEF.md
# Transactional access-set tracker

This block keeps the speculative bookkeeping of a small private cache while a hardware transaction runs. For every cache line it holds one flag recording that the transaction has read the line and one recording that the transaction has written it. Local loads and stores made inside the transaction set these flags. Remote write snoops are compared against the read flags, and a hit ends the transaction with an abort.

A store that makes the transaction's first write to a line that is already dirty is held back. The block first asks for a writeback of that line, so that the old committed data reaches memory before speculative data overwrites it. The store goes ahead once the writeback is acknowledged.

Ending a transaction without a conflict commits it: both flag sets are wiped in a single cycle. An abort, whether commanded or caused by a conflict, presents a per-line invalidate vector of the written lines and wipes both flag sets. The abort indication then stays up until it is acknowledged. Register checkpointing, the data arrays and the bus protocol sit outside the block.

Top module: `txn_track`

## Requirements
- R1: After reset, in_tx, abort_flag, wb_req, inval_valid and commit_done are all 0, inval_vec is all zeros, and acc_ready is 1.
- R2: tx_begin while no transaction is open and no abort is pending sets in_tx one cycle later.
- R3: Inside a transaction, a load (acc_valid=1, acc_write=0) to line n marks line n as read. A later snoop_valid with snoop_idx=n raises abort_flag one cycle after the snoop.
- R4: A snoop to a line that has not been read in the current transaction, including a line that has only been written, does not raise abort_flag.
- R5: Inside a transaction, a store (acc_write=1) marks its line as written. In the cycle abort_flag rises, inval_valid is 1 for exactly one cycle, and inval_vec has bit n set for exactly the lines written in the aborted transaction. inval_vec holds that value until the abort is acknowledged.
- R6: When a store inside a transaction is the first write to line n and acc_dirty=1, acc_ready is 0 in that cycle. wb_req=1 with wb_idx=n follows one cycle later and stays asserted, with acc_ready 0, until wb_ack. One cycle after wb_ack, wb_req is 0 and line n counts as written. A store to a line already written in the transaction never requests a writeback.
- R7: tx_end with no conflict in the same cycle pulses commit_done for one cycle, clears in_tx one cycle later, and clears both flag sets. Neither a snoop nor an abort in a later transaction sees lines from the committed one.
- R8: tx_abort inside a transaction, including while a writeback is outstanding, raises abort_flag one cycle later and clears in_tx and wb_req. abort_flag stays 1 until abort_ack, and is 0 one cycle after it.
- R9: Loads and stores outside a transaction set no flag and never request a writeback. A snoop outside a transaction never raises abort_flag.
- R10: While abort_flag is 1, local accesses are ignored: acc_ready is 1, no writeback is requested, and no flag is set.
- R11: A conflicting snoop in the same cycle as tx_end aborts the transaction: abort_flag rises and commit_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_end | input | 1 | End the transaction (commit unless it conflicts) |
| tx_abort | input | 1 | Abort the open transaction |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_idx | input | log2(LINES) | Line of the local access |
| acc_dirty | input | 1 | The accessed line is currently dirty |
| acc_ready | output | 1 | Local access may complete this cycle |
| wb_req | output | 1 | Writeback request for a dirty line |
| wb_idx | output | log2(LINES) | Line to write back |
| wb_ack | input | 1 | Writeback finished |
| snoop_valid | input | 1 | Remote write observed |
| snoop_idx | input | log2(LINES) | Line of the remote write |
| abort_flag | output | 1 | Transaction aborted, held until acknowledged |
| abort_ack | input | 1 | Acknowledge and clear the abort |
| inval_valid | output | 1 | One-cycle pulse marking a new inval_vec |
| inval_vec | output | LINES | Lines to invalidate after the abort |
| commit_done | output | 1 | One-cycle pulse on commit |
| in_tx | output | 1 | Transaction open |

## Verification
All results except acc_ready are registered. in_tx, abort_flag, wb_req, inval_valid, inval_vec and commit_done therefore change one cycle after the edge that samples their cause. acc_ready is combinational and reflects the stall in the same cycle the store is presented. The bench drives inputs one time unit after a rising edge. It reads acc_ready after that settling delay, still in the same cycle, and reads every registered result one time unit after the following rising edge. Pulse outputs are also read one cycle later to confirm they have dropped.

// File: rtl/txn_track.sv
module txn_track #(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin,
  input  logic             tx_end,
  input  logic             tx_abort,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_dirty,
  output logic             acc_ready,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ack,
  input  logic             snoop_valid,
  input  logic [IDX_W-1:0] snoop_idx,
  output logic             abort_flag,
  input  logic             abort_ack,
  output logic             inval_valid,
  output logic [LINES-1:0] inval_vec,
  output logic             commit_done,
  output logic             in_tx
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WB, S_ABT} st_t;

  st_t              st;
  logic [LINES-1:0] rd_bits, wr_bits;

  logic active, wbwait, open_tx, conflict, go_abort, go_commit;
  logic quiet, need_clean, rec_rd, rec_wr, go_wb;

  assign active     = (st == S_ACT);
  assign wbwait     = (st == S_WB);
  assign open_tx    = active | wbwait;
  assign conflict   = open_tx & snoop_valid & rd_bits[snoop_idx];
  assign go_abort   = conflict | (open_tx & tx_abort);
  assign go_commit  = active & tx_end & ~go_abort;
  assign quiet      = active & ~go_abort & ~tx_end;
  assign need_clean = acc_valid & acc_write & acc_dirty & ~wr_bits[acc_idx];
  assign rec_rd     = quiet & acc_valid & ~acc_write;
  assign rec_wr     = quiet & acc_valid & acc_write & ~need_clean;
  assign go_wb      = quiet & need_clean;

  assign acc_ready  = ~(wbwait | (active & need_clean));
  assign abort_flag = (st == S_ABT);
  assign in_tx      = open_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rd_bits     <= '0;
      wr_bits     <= '0;
      wb_req      <= 1'b0;
      wb_idx      <= '0;
      inval_vec   <= '0;
      inval_valid <= 1'b0;
      commit_done <= 1'b0;
    end else begin
      inval_valid <= 1'b0;
      commit_done <= 1'b0;
      if (go_abort) begin
        inval_vec   <= wr_bits;
        inval_valid <= 1'b1;
        rd_bits     <= '0;
        wr_bits     <= '0;
        wb_req      <= 1'b0;
        st          <= S_ABT;
      end else begin
        case (st)
          S_IDLE: if (tx_begin) st <= S_ACT;
          S_ACT: begin
            if (go_commit) begin
              rd_bits     <= '0;
              wr_bits     <= '0;
              commit_done <= 1'b1;
              st          <= S_IDLE;
            end else if (rec_rd) begin
              rd_bits[acc_idx] <= 1'b1;
            end else if (rec_wr) begin
              wr_bits[acc_idx] <= 1'b1;
            end else if (go_wb) begin
              wb_req <= 1'b1;
              wb_idx <= acc_idx;
              st     <= S_WB;
            end
          end
          S_WB: if (wb_ack) begin
            wr_bits[wb_idx] <= 1'b1;
            wb_req          <= 1'b0;
            st              <= S_ACT;
          end
          S_ABT: if (abort_ack) begin
            inval_vec <= '0;
            st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/txn_track_chk.sv
module txn_track_chk #(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_ready,
  input logic             wb_req,
  input logic             snoop_valid,
  input logic             abort_flag,
  input logic             abort_ack,
  input logic             inval_valid,
  input logic             commit_done,
  input logic             in_tx
);

  AST_WB_STALLS: assert property (@(posedge clk) disable iff (!rst_n) wb_req |-> !acc_ready); // R6
  AST_WB_IN_TX: assert property (@(posedge clk) disable iff (!rst_n) wb_req |-> in_tx); // R6
  AST_INVAL_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort_flag) |-> inval_valid); // R5
  AST_INVAL_ONLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n) inval_valid |-> abort_flag); // R5
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (abort_flag && !abort_ack) |=> abort_flag); // R8
  AST_ABORT_ACKED: assert property (@(posedge clk) disable iff (!rst_n) (abort_flag && abort_ack) |=> !abort_flag); // R8
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) commit_done |-> (!in_tx && !abort_flag)); // R7
  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (!in_tx && !abort_flag && snoop_valid) |=> !abort_flag); // R9
  AST_PENDING_READY: assert property (@(posedge clk) disable iff (!rst_n) abort_flag |-> acc_ready); // R10

endmodule

bind txn_track txn_track_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .wb_req(wb_req),
  .snoop_valid(snoop_valid), .abort_flag(abort_flag), .abort_ack(abort_ack),
  .inval_valid(inval_valid), .commit_done(commit_done), .in_tx(in_tx)
);

// File: tb/tb_txn_track.sv
module tb_txn_track;
  localparam int CLK_P = 10;
  localparam int LINES = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_end = 0, tx_abort = 0;
  logic acc_valid = 0, acc_write = 0, acc_dirty = 0;
  logic [IW-1:0] acc_idx = '0, snoop_idx = '0;
  logic wb_ack = 0, snoop_valid = 0, abort_ack = 0;
  logic acc_ready, wb_req, abort_flag, inval_valid, commit_done, in_tx;
  logic [IW-1:0] wb_idx;
  logic [LINES-1:0] inval_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  txn_track #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end), .tx_abort(tx_abort),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx), .acc_dirty(acc_dirty),
    .acc_ready(acc_ready), .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
    .snoop_valid(snoop_valid), .snoop_idx(snoop_idx), .abort_flag(abort_flag),
    .abort_ack(abort_ack), .inval_valid(inval_valid), .inval_vec(inval_vec),
    .commit_done(commit_done), .in_tx(in_tx)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tx_open();
    tx_begin = 1; step(); tx_begin = 0;
  endtask

  task automatic access(bit w, int idx, bit dirty);
    acc_valid = 1; acc_write = w; acc_idx = IW'(idx); acc_dirty = dirty;
    step();
    acc_valid = 0; acc_write = 0; acc_dirty = 0;
  endtask

  task automatic snoop(int idx);
    snoop_valid = 1; snoop_idx = IW'(idx); step(); snoop_valid = 0;
  endtask

  task automatic ack_abort();
    abort_ack = 1; step(); abort_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 in_tx", in_tx, 0);
    chk("R1 abort_flag", abort_flag, 0);
    chk("R1 wb_req", wb_req, 0);
    chk("R1 inval_valid", inval_valid, 0);
    chk("R1 inval_vec", inval_vec, 0);
    chk("R1 commit_done", commit_done, 0);
    chk("R1 acc_ready", acc_ready, 1);
  endtask

  task automatic t_commit();
    tx_open();
    chk("R2 in_tx after begin", in_tx, 1);
    access(0, 3, 0);
    access(1, 5, 0);
    tx_end = 1; step(); tx_end = 0;
    chk("R7 commit_done", commit_done, 1);
    chk("R7 in_tx cleared", in_tx, 0);
    step();
    chk("R7 commit pulse drops", commit_done, 0);
    tx_open();
    snoop(3);
    chk("R7 read set cleared", abort_flag, 0);
    tx_abort = 1; step(); tx_abort = 0;
    chk("R8 abort raised", abort_flag, 1);
    chk("R7 write set cleared", inval_vec, 0);
    ack_abort();
  endtask

  task automatic t_conflict();
    tx_open();
    access(0, 2, 0);
    access(0, 9, 0);
    access(1, 4, 0);
    snoop(4);
    chk("R4 snoop on written-only line", abort_flag, 0);
    snoop(7);
    chk("R4 snoop on untouched line", abort_flag, 0);
    snoop(9);
    chk("R3 snoop on read line aborts", abort_flag, 1);
    chk("R5 inval_valid pulse", inval_valid, 1);
    chk("R5 inval_vec", inval_vec, 32'h0010);
    chk("R8 in_tx dropped", in_tx, 0);
    step();
    chk("R5 inval_valid one cycle", inval_valid, 0);
    chk("R5 inval_vec held", inval_vec, 32'h0010);
    acc_valid = 1; acc_write = 1; acc_idx = 6; acc_dirty = 1; #1;
    chk("R10 ready while pending", acc_ready, 1);
    step(); acc_valid = 0; acc_write = 0; acc_dirty = 0;
    chk("R10 no writeback while pending", wb_req, 0);
    access(0, 11, 0);
    repeat (3) step();
    chk("R8 abort held", abort_flag, 1);
    ack_abort();
    chk("R8 abort cleared by ack", abort_flag, 0);
    chk("R8 idle after ack", in_tx, 0);
    tx_open();
    snoop(11);
    chk("R10 pending read ignored", abort_flag, 0);
    tx_abort = 1; step(); tx_abort = 0;
    chk("R10 pending write ignored", inval_vec, 0);
    ack_abort();
  endtask

  task automatic t_clean();
    tx_open();
    acc_valid = 1; acc_write = 1; acc_idx = 8; acc_dirty = 1; #1;
    chk("R6 stall same cycle", acc_ready, 0);
    step();
    chk("R6 wb_req", wb_req, 1);
    chk("R6 wb_idx", wb_idx, 8);
    repeat (3) step();
    chk("R6 wb_req held", wb_req, 1);
    chk("R6 still stalled", acc_ready, 0);
    wb_ack = 1; step(); wb_ack = 0;
    chk("R6 wb_req dropped", wb_req, 0);
    chk("R6 store released", acc_ready, 1);
    step();
    acc_valid = 0; acc_write = 0; acc_dirty = 0;
    acc_valid = 1; acc_write = 1; acc_idx = 8; acc_dirty = 1; #1;
    chk("R6 second write no stall", acc_ready, 1);
    step(); acc_valid = 0; acc_write = 0; acc_dirty = 0;
    chk("R6 second write no wb", wb_req, 0);
    access(1, 1, 0);
    tx_abort = 1; step(); tx_abort = 0;
    chk("R5 written lines invalidated", inval_vec, 32'h0102);
    ack_abort();
  endtask

  task automatic t_outside();
    acc_valid = 1; acc_write = 1; acc_idx = 2; acc_dirty = 1; #1;
    chk("R9 idle store ready", acc_ready, 1);
    step(); acc_valid = 0; acc_write = 0; acc_dirty = 0;
    chk("R9 idle store no wb", wb_req, 0);
    access(0, 1, 0);
    snoop(1);
    chk("R9 idle snoop no abort", abort_flag, 0);
    tx_open();
    snoop(1);
    chk("R9 idle read not recorded", abort_flag, 0);
    tx_abort = 1; step(); tx_abort = 0;
    chk("R9 idle write not recorded", inval_vec, 0);
    ack_abort();
  endtask

  task automatic t_race();
    tx_open();
    access(0, 12, 0);
    tx_end = 1; snoop_valid = 1; snoop_idx = 12;
    step();
    tx_end = 0; snoop_valid = 0;
    chk("R11 conflict beats commit", abort_flag, 1);
    chk("R11 no commit", commit_done, 0);
    ack_abort();
    tx_open();
    access(0, 0, 0);
    acc_valid = 1; acc_write = 1; acc_idx = 13; acc_dirty = 1;
    step();
    chk("R6 wb pending", wb_req, 1);
    tx_abort = 1; step(); tx_abort = 0;
    acc_valid = 0; acc_write = 0; acc_dirty = 0;
    chk("R8 abort during writeback", abort_flag, 1);
    chk("R8 wb_req cleared", wb_req, 0);
    chk("R5 unconfirmed line not invalidated", inval_vec, 0);
    ack_abort();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_commit();
    t_conflict();
    t_clean();
    t_outside();
    t_race();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule